// File: doc/BRIEF.md
# SPI Master with Chip-Select Hold

This block is a single-select SPI master. Software drives it through one 32-bit transmit word written over a byte-strobed write port. The low half of the word holds the data to shift out. The top byte carries two control fields: a chip-select hold flag and a format index. The format index picks clock polarity, clock phase, word length and bit-clock divider. Each received word lands in a one-entry receive buffer, which is drained over a valid/ready port. A flag marks an overrun.

The hold flag lets several words run under one chip-select assertion, which memory-style slaves need for command, address and data sequences. The hold flag and the format index can be written together with a data word, or on their own by a write that leaves the data byte lanes untouched. A write of that second kind changes control state and starts no transfer. It is also the way to end a held sequence without sending another word. The receive engine counts its own clock edges and never watches the pin. A change of polarity between held words therefore cannot add a bit.

Back-pressure rules: the write port asserts `wr_ready` only when no transfer is running. A write offered while it is low stays pending until it rises. The receive port holds `rx_valid` and `rx_data` until a cycle with `rx_ready` high. The engine never stalls on a full buffer. A new word that finds the buffer full replaces the old word and raises the overrun flag.

Top module: `spi_hold_master`

## Requirements
- R1: A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. An accepted write with `wr_strb[0]` or `wr_strb[1]` set starts one transfer. An accepted write that sets only `wr_strb[3]` updates the control fields, starts no transfer and produces no SCLK edge.
- R2: Transmit data sits in bits 15:0 and the format index in bits 25:24. Format f gives CPOL = f[0], CPHA = f[1], a word length of 16 bits for f < 2 and 8 bits otherwise, and a half-period of f+1 clock cycles. The low word-length bits of the data go out MSB first. With CPHA 0, MISO is sampled on leading edges. With CPHA 1, it is sampled on trailing edges.
- R3: Bit 28 is the hold flag. After a word sent with the hold flag at 1, `cs_n` stays low once the transfer ends. After a word sent with the hold flag at 0, `cs_n` goes high. A data-only write uses the last hold value stored. Writing the hold flag alone never drives `cs_n` low.
- R4: While words follow a held word, `cs_n` stays low in every cycle, including the cycle in which the next word starts.
- R5: A control-only write with the hold flag at 0, made while `cs_n` is held low and the engine is idle, drives `cs_n` high on that edge. It sends no data and produces no SCLK edge.
- R6: Each transfer has exactly 2 × word-length SCLK toggles. Between transfers SCLK rests at the CPOL of the last transfer. A change of CPOL between held words adds no received bit.
- R7: The first transfer after reset uses the hold flag written with it (or stored before it), with no leftover state.
- R8: One cycle after a transfer ends, `rx_valid` rises and `rx_data` holds the received bits, right-aligned and zero-extended. A cycle with `rx_valid` and `rx_ready` both high clears `rx_valid`.
- R9: If a word arrives while `rx_valid` is high and no read is taken in that cycle, `rx_data` takes the new word and `rx_overrun` is set. A read clears `rx_overrun`.
- R10: If a read and a new word fall in the same cycle, `rx_valid` stays high, `rx_data` takes the new word and `rx_overrun` stays low.
- R11: After reset `cs_n` = 1, `sclk` = 0, `rx_valid` = 0, `rx_overrun` = 0 and `wr_ready` = 1.
- R12: Format and hold are latched when a transfer starts. `wr_ready` stays low for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Engine idle, write can be taken |
| wr_data | input | 32 | Transmit word: data 15:0, format 25:24, hold 28 |
| wr_strb | input | 4 | Byte-lane strobes |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Receive buffer read |
| rx_data | output | 16 | Received word |
| rx_overrun | output | 1 | A word overwrote an unread one |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
A receive-buffer read and the arrival of a new word can land on the same clock edge. The bench leaves one word unread, starts a second, and counts cycles from the accepted write to the edge where the buffer loads. It raises `rx_ready` for exactly that edge. The result passes only if the flag stays set, the overrun flag stays clear and the buffer holds the second word.

// File: rtl/spi_hold_pkg.sv
`timescale 1ns/1ps
package spi_hold_pkg;
  localparam int TX_DATA_W = 16;
  localparam int HOLD_POS  = 28;
  localparam int FMT_LSB   = 24;
  localparam int FMT_W     = 2;
  localparam int LEN_W     = 5;
  localparam int DIV_W     = 3;
  localparam int ECNT_W    = LEN_W + 1;
  localparam int DATA_LANES = TX_DATA_W / 8;

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic [LEN_W-1:0]  len;
    logic [DIV_W-1:0]  div;
  } fmt_t;

  // Format index to clocking parameters: bit0 polarity, bit1 phase,
  // bit1 also halves the word length, divider grows with the index.
  function automatic fmt_t fmt_decode(input logic [FMT_W-1:0] f);
    fmt_t r;
    r.cpol = f[0];
    r.cpha = f[1];
    r.len  = LEN_W'(TX_DATA_W >> f[1]);
    r.div  = DIV_W'(f) + DIV_W'(1);
    return r;
  endfunction
endpackage

// File: rtl/spi_hold_regs.sv
`timescale 1ns/1ps
module spi_hold_regs
  import spi_hold_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_fire,
  input  logic [31:0]          wr_data,
  input  logic [3:0]           wr_strb,
  output logic                 start,
  output logic                 release_cs,
  output logic [TX_DATA_W-1:0] tx_word,
  output logic                 start_hold,
  output fmt_t                 start_fmt
);
  logic [TX_DATA_W-1:0] data_q, data_n;
  logic                 hold_q, hold_n;
  logic [FMT_W-1:0]     fmt_q, fmt_n;
  logic                 data_touch;

  for (genvar g = 0; g < DATA_LANES; g++) begin : g_lane
    assign data_n[g*8 +: 8] = wr_strb[g] ? wr_data[g*8 +: 8] : data_q[g*8 +: 8];
  end

  assign data_touch = |wr_strb[DATA_LANES-1:0];
  assign hold_n     = wr_strb[3] ? wr_data[HOLD_POS] : hold_q;
  assign fmt_n      = wr_strb[3] ? wr_data[FMT_LSB +: FMT_W] : fmt_q;

  assign start      = wr_fire && data_touch;
  assign release_cs = wr_fire && !data_touch && wr_strb[3] && !wr_data[HOLD_POS];
  assign tx_word    = data_n;
  assign start_hold = hold_n;
  assign start_fmt  = fmt_decode(fmt_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      hold_q <= 1'b0;
      fmt_q  <= '0;
    end else if (wr_fire) begin
      data_q <= data_n;
      hold_q <= hold_n;
      fmt_q  <= fmt_n;
    end
  end
endmodule

// File: rtl/spi_hold_shifter.sv
`timescale 1ns/1ps
module spi_hold_shifter
  import spi_hold_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 release_cs,
  input  logic [TX_DATA_W-1:0] tx_word,
  input  logic                 start_hold,
  input  fmt_t                 start_fmt,
  input  logic                 miso,
  output logic                 idle,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 cs_n,
  output logic                 done,
  output logic [TX_DATA_W-1:0] rx_word
);
  logic                 busy_q;
  fmt_t                 cfg_q;
  logic                 hold_q;
  logic [DIV_W-1:0]     cnt_q;
  logic [ECNT_W-1:0]    ecnt_q;
  logic [TX_DATA_W-1:0] tx_sh, rx_sh;
  logic                 sclk_q, cs_n_q, done_q;
  logic                 leading, do_sample, do_shift, last_edge;
  logic [ECNT_W-1:0]    edges_total;

  assign edges_total = {cfg_q.len, 1'b0};
  assign last_edge   = (ecnt_q == edges_total);
  // Toggles are numbered from 1; odd ones are leading edges.
  assign leading     = ~ecnt_q[0];
  assign do_sample   = cfg_q.cpha ? !leading : leading;
  assign do_shift    = cfg_q.cpha ? (leading && ecnt_q != '0)
                                  : (!leading && ecnt_q != edges_total - ECNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cfg_q  <= '0;
      hold_q <= 1'b0;
      cnt_q  <= '0;
      ecnt_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          cfg_q  <= start_fmt;
          hold_q <= start_hold;
          cnt_q  <= start_fmt.div - DIV_W'(1);
          ecnt_q <= '0;
          tx_sh  <= tx_word << (ECNT_W'(TX_DATA_W) - ECNT_W'(start_fmt.len));
          rx_sh  <= '0;
          sclk_q <= start_fmt.cpol;
          cs_n_q <= 1'b0;
        end else if (release_cs) begin
          cs_n_q <= 1'b1;
        end
      end else if (cnt_q == '0) begin
        cnt_q <= cfg_q.div - DIV_W'(1);
        if (last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cs_n_q <= !hold_q;
        end else begin
          sclk_q <= ~sclk_q;
          ecnt_q <= ecnt_q + ECNT_W'(1);
          if (do_sample) rx_sh <= {rx_sh[TX_DATA_W-2:0], miso};
          if (do_shift)  tx_sh <= {tx_sh[TX_DATA_W-2:0], 1'b0};
        end
      end else begin
        cnt_q <= cnt_q - DIV_W'(1);
      end
    end
  end

  assign idle    = !busy_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_sh[TX_DATA_W-1];
  assign cs_n    = cs_n_q;
  assign done    = done_q;
  assign rx_word = rx_sh;
endmodule

// File: rtl/spi_hold_rxbuf.sv
`timescale 1ns/1ps
module spi_hold_rxbuf
  import spi_hold_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic [TX_DATA_W-1:0] rx_word,
  input  logic                 rx_ready,
  output logic                 rx_valid,
  output logic [TX_DATA_W-1:0] rx_data,
  output logic                 rx_overrun
);
  logic                 full_q, ovr_q, rd;
  logic [TX_DATA_W-1:0] buf_q;

  assign rd = full_q && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (rd) ovr_q <= 1'b0;
      if (done) begin
        buf_q  <= rx_word;
        full_q <= 1'b1;
        if (full_q && !rd) ovr_q <= 1'b1;
      end else if (rd) begin
        full_q <= 1'b0;
      end
    end
  end

  assign rx_valid   = full_q;
  assign rx_data    = buf_q;
  assign rx_overrun = ovr_q;
endmodule

// File: rtl/spi_hold_master.sv
`timescale 1ns/1ps
module spi_hold_master
  import spi_hold_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [31:0]          wr_data,
  input  logic [3:0]           wr_strb,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [TX_DATA_W-1:0] rx_data,
  output logic                 rx_overrun,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic                 cs_n
);
  logic                 idle, wr_fire, start, release_cs, start_hold, done;
  logic [TX_DATA_W-1:0] tx_word, rx_word;
  fmt_t                 start_fmt;

  assign wr_ready = idle;
  assign wr_fire  = wr_valid && idle;

  spi_hold_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_data(wr_data),
    .wr_strb(wr_strb), .start(start), .release_cs(release_cs),
    .tx_word(tx_word), .start_hold(start_hold), .start_fmt(start_fmt)
  );

  spi_hold_shifter shift_i (
    .clk(clk), .rst_n(rst_n), .start(start), .release_cs(release_cs),
    .tx_word(tx_word), .start_hold(start_hold), .start_fmt(start_fmt),
    .miso(miso), .idle(idle), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .done(done), .rx_word(rx_word)
  );

  spi_hold_rxbuf rx_i (
    .clk(clk), .rst_n(rst_n), .done(done), .rx_word(rx_word),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_overrun(rx_overrun)
  );
endmodule

// File: rtl/spi_hold_master_chk.sv
`timescale 1ns/1ps
module spi_hold_master_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic rx_overrun,
  input logic sclk,
  input logic cs_n
);
  // R4
  busy_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !cs_n);

  // R5
  cs_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> wr_ready);

  // R6
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && $past(wr_ready)) |-> $stable(sclk));

  // R8
  rx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_valid) |-> $past(rx_ready));

  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> ($past(rx_valid) && rx_valid));
endmodule

bind spi_hold_master spi_hold_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_overrun(rx_overrun), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/spi_hold_master_tb_top.sv
`timescale 1ns/1ps
module spi_hold_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_strb = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [15:0] rx_data;
  logic        rx_overrun;
  logic        sclk, mosi, miso, cs_n;
  logic        invert = 1'b0;
  logic        watch_cs = 1'b0;
  logic        cs_glitch = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;
  assign miso = invert ? ~mosi : mosi;

  spi_hold_master dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_strb(wr_strb), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_overrun(rx_overrun),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always @(negedge clk) if (watch_cs && cs_n) cs_glitch = 1'b1;

  function automatic logic [31:0] word(input logic hold, input logic [1:0] f, input logic [15:0] d);
    return {3'b000, hold, 2'b00, f, 8'h00, d};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_strb = s;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; wr_strb = '0;
  endtask

  // Runs until the engine is idle again; returns SCLK toggles seen.
  task automatic finish(output int tog);
    logic prev;
    prev = sclk; tog = 0;
    while (!wr_ready) begin
      @(negedge clk);
      if (sclk != prev) tog++;
      prev = sclk;
    end
    @(negedge clk);
  endtask

  task automatic rd();
    @(negedge clk); rx_ready = 1'b1;
    @(posedge clk);
    @(negedge clk); rx_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int tog;
    logic [15:0] pats [4];
    pats[0] = 16'hA5C3; pats[1] = 16'h0001; pats[2] = 16'h8000; pats[3] = 16'h6F29;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n == 1'b1 && sclk == 1'b0 && rx_valid == 1'b0 && rx_overrun == 1'b0 && wr_ready == 1'b1,
        "R11", "reset outputs", {cs_n, sclk, rx_valid, rx_overrun, wr_ready}, 32'b10001);
    rst_n = 1'b1;

    // R7 first transfer after reset honours hold written with it
    wr(word(1'b1, 2'd0, 16'h1234), 4'hF);
    finish(tog);
    chk(cs_n == 1'b0, "R7", "cs held after first word", cs_n, 0);
    chk(rx_data == 16'h1234, "R2", "first word loopback", rx_data, 16'h1234);
    rd();

    // R1 control-only write: change polarity, keep hold, no transfer
    watch_cs = 1'b1;
    wr(word(1'b1, 2'd1, 16'h0000), 4'b1000);
    chk(wr_ready == 1'b1 && rx_valid == 1'b0 && sclk == 1'b0, "R1", "control write starts nothing",
        {wr_ready, rx_valid, sclk}, 3'b100);
    // R6 polarity change between held words adds no bit
    wr(word(1'b1, 2'd1, 16'hBEEF), 4'b0011);
    finish(tog);
    chk(tog == 32, "R6", "toggles after polarity change", tog, 32);
    chk(rx_data == 16'hBEEF, "R6", "data after polarity change", rx_data, 16'hBEEF);
    chk(sclk == 1'b1, "R6", "idle sclk at new cpol", sclk, 1);
    rd();
    wr(word(1'b1, 2'd2, 16'h00C7), 4'hF);
    finish(tog);
    rd();
    // R4 no chip-select glitch across held words
    chk(cs_glitch == 1'b0 && cs_n == 1'b0, "R4", "cs stayed low", {cs_glitch, cs_n}, 0);
    watch_cs = 1'b0;

    // R5 standalone hold clear releases cs without clocks
    wr(word(1'b0, 2'd2, 16'h0000), 4'b1000);
    chk(cs_n == 1'b1, "R5", "cs released", cs_n, 1);
    chk(wr_ready == 1'b1 && rx_valid == 1'b0, "R5", "no data sent", {wr_ready, rx_valid}, 2'b10);

    // R3 hold alone does not assert cs; data-only write uses stored hold
    wr(word(1'b1, 2'd0, 16'h0000), 4'b1000);
    @(negedge clk);
    chk(cs_n == 1'b1, "R3", "hold alone keeps cs high", cs_n, 1);
    wr(word(1'b0, 2'd0, 16'h5A5A), 4'b0011);
    finish(tog);
    chk(cs_n == 1'b0, "R3", "stored hold applied", cs_n, 0);
    rd();
    wr(word(1'b0, 2'd0, 16'h0000), 4'b1000);

    // R2/R6/R8 sweep: every format, several patterns, both MISO polarities
    for (int f = 0; f < 4; f++) begin
      for (int p = 0; p < 4; p++) begin
        int len;
        logic [15:0] mask, exp;
        invert = p[0];
        len  = (f < 2) ? 16 : 8;
        mask = (len == 16) ? 16'hFFFF : 16'h00FF;
        exp  = (invert ? ~pats[p] : pats[p]) & mask;
        wr(word(1'b0, 2'(f), pats[p] ^ 16'(f * 16'h1111)), 4'hF);
        exp  = (invert ? ~(pats[p] ^ 16'(f * 16'h1111)) : (pats[p] ^ 16'(f * 16'h1111))) & mask;
        // R12 busy refuses writes
        chk(wr_ready == 1'b0, "R12", "busy during transfer", wr_ready, 0);
        finish(tog);
        chk(rx_valid == 1'b1, "R8", "rx_valid after word", rx_valid, 1);
        chk(rx_data == exp, "R2", "received word", rx_data, exp);
        chk(tog == 2 * len, "R6", "toggle count", tog, 2 * len);
        chk(sclk == f[0], "R6", "idle sclk level", sclk, f[0]);
        chk(cs_n == 1'b1, "R3", "cs released without hold", cs_n, 1);
        rd();
        chk(rx_valid == 1'b0 && rx_overrun == 1'b0, "R8", "buffer drained", {rx_valid, rx_overrun}, 0);
      end
    end
    invert = 1'b0;

    // R9 overrun
    wr(word(1'b0, 2'd0, 16'h1111), 4'hF); finish(tog);
    wr(word(1'b0, 2'd0, 16'h2222), 4'hF); finish(tog);
    chk(rx_overrun == 1'b1, "R9", "overrun set", rx_overrun, 1);
    chk(rx_data == 16'h2222, "R9", "newest word kept", rx_data, 16'h2222);
    rd();
    chk(rx_overrun == 1'b0 && rx_valid == 1'b0, "R9", "read clears overrun", {rx_overrun, rx_valid}, 0);

    // R10 read and arrival in the same cycle: load edge is 1*(2*16+1)+1 = 34 edges after start
    wr(word(1'b0, 2'd0, 16'h3333), 4'hF); finish(tog);
    wr(word(1'b0, 2'd0, 16'h4444), 4'hF);
    repeat (33) @(negedge clk);
    rx_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b1, "R10", "valid kept", rx_valid, 1);
    chk(rx_overrun == 1'b0, "R10", "no overrun", rx_overrun, 0);
    chk(rx_data == 16'h4444, "R10", "new word held", rx_data, 16'h4444);
    rd();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule